// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This block turns an IEEE-754 single-precision value into a fixed-point integer. Before the integer is formed, the operand is multiplied by two raised to a run-time fraction-bit count. The integer is always rounded toward zero. Any value that does not fit the chosen destination range is clamped to that range's nearest limit, and an invalid-operation flag is raised.

Each conversion can pick a signed or an unsigned result, and a 16-bit or a 32-bit result. A 16-bit result is widened to fill the 32-bit output. The fraction-bit count is not given directly. The caller supplies a five-bit immediate in two pieces, and the unit subtracts that immediate from the result width.

The unit takes one operand per cycle and has one register stage. The result and its two flags (invalid and inexact) appear on the cycle after the operand is presented.

Top module: `f2x_conv`

## Requirements
- R1: `out_valid` equals the previous cycle's `in_valid`. `result`, `invalid` and `inexact` show the conversion presented on that previous cycle. While `rst` is high, all four outputs are cleared to 0 on the next clock edge.
- R2: The immediate is {`imm_hi`[3:0], `imm_lo`}, so `imm_lo` is bit 0. The width W is 16 in halfword mode and 32 in word mode. The fraction-bit count F is W minus the immediate, or 0 when the immediate exceeds W. The operand is multiplied by 2^F before conversion.
- R3: The scaled value is truncated toward zero. `inexact` is 1 exactly when that truncation drops a nonzero fraction and `invalid` is 0.
- R4: Signed word results outside the range are clamped to 32'h80000000 (below) or 32'h7FFFFFFF (above), with `invalid` = 1.
- R5: Signed halfword results are clamped to -32768 (32'hFFFF8000) or +32767 (32'h00007FFF), with `invalid` = 1. Every signed halfword result is sign-extended from bit 15.
- R6: In unsigned modes, a negative operand whose truncated magnitude is nonzero gives 0 with `invalid` = 1. A negative operand that truncates to zero gives 0 and is not invalid. Values above the range give 32'h0000FFFF (halfword) or 32'hFFFFFFFF (word), with `invalid` = 1. Halfword results are zero-extended.
- R7: A NaN operand (exponent all ones, mantissa nonzero) gives 0 with `invalid` = 1 and `inexact` = 0.
- R8: An infinity is clamped to the limit on its own sign's side of the selected range, with `invalid` = 1.
- R9: Zero of either sign gives 0 with no flags. A nonzero denormal gives 0 with `invalid` = 0 and `inexact` = 1.
- R10: The flags are not sticky. Each conversion's flags depend only on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 32 | Single-precision input |
| is_signed | input | 1 | 1 = signed result, 0 = unsigned |
| is_half | input | 1 | 1 = 16-bit result, 0 = 32-bit |
| imm_lo | input | 1 | Immediate bit 0 |
| imm_hi | input | 4 | Immediate bits 4..1 |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Fixed-point result, widened for halfword |
| invalid | output | 1 | Clamped, or NaN operand |
| inexact | output | 1 | Truncation dropped nonzero bits |

## Verification
The directed patterns cover several distinct cases:
- Exact in-range values, which isolate the power-of-two scaling.
- Values with fractional parts, which separate truncation toward zero from rounding.
- Values exactly at each range limit and one step beyond it, which tell clamping apart from off-by-one limit errors in all four modes.
- Special encodings: NaN, both infinities, signed zeros and denormals.

Small negative inputs in unsigned mode distinguish truncate-then-check from check-then-truncate. Immediates above 16 in halfword mode probe the clamped fraction count. A long run of operands with exponents concentrated near the integer range then compares every cycle against a reference model that uses real arithmetic.

// File: rtl/f2x_pkg.sv
package f2x_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int BIAS    = 127;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int IMM_W   = 5;
    localparam int FRAC_W  = $clog2(WORD_W + 1);
    localparam int SH_W    = 11;
    // exponent offset that turns the integer significand into a plain integer
    localparam int SIG_OFS = BIAS + MAN_W;
    // left shifts at or above this push any significand past the word range
    localparam int BIG_SH  = WORD_W - MAN_W;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef struct packed {
        logic             sign;
        fp_class_e        cls;
        logic [EXP_W-1:0] exp;
        logic [MAN_W:0]   sig;
    } fp_fields_t;

    typedef struct packed {
        logic              sign;
        logic              nan;
        logic              big;
        logic              lost;
        logic [WORD_W-1:0] mag;
    } scaled_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              invalid;
        logic              inexact;
    } conv_res_t;

    // fraction count: result width minus the immediate, floored at zero
    function automatic logic [FRAC_W-1:0] frac_count(input logic half,
                                                     input logic [IMM_W-1:0] imm);
        logic [FRAC_W-1:0] w;
        logic [FRAC_W-1:0] i;
        w = half ? FRAC_W'(HALF_W) : FRAC_W'(WORD_W);
        i = FRAC_W'(imm);
        return (i > w) ? '0 : (w - i);
    endfunction

endpackage

// File: rtl/f2x_unpack.sv
module f2x_unpack
    import f2x_pkg::*;
(
    input  logic [FP_W-1:0] operand,
    output fp_fields_t      fields
);
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;

    assign e = operand[FP_W-2 -: EXP_W];
    assign m = operand[MAN_W-1:0];

    always_comb begin
        fields.sign = operand[FP_W-1];
        fields.exp  = e;
        fields.sig  = {1'b0, m};
        if (e == '1) begin
            fields.cls = (m != '0) ? CLS_NAN : CLS_INF;
        end else if (e == '0) begin
            fields.cls = (m != '0) ? CLS_SUB : CLS_ZERO;
        end else begin
            fields.cls = CLS_NORM;
            fields.sig = {1'b1, m};
        end
    end
endmodule

// File: rtl/f2x_scale.sv
module f2x_scale
    import f2x_pkg::*;
(
    input  fp_fields_t        fields,
    input  logic [FRAC_W-1:0] frac,
    output scaled_t           sc
);
    logic signed [SH_W-1:0] sh;
    logic        [SH_W-1:0] rsh;
    logic        [MAN_W:0]  keep_mask;

    assign sh  = $signed(SH_W'(fields.exp)) + $signed(SH_W'(frac))
               - $signed(SH_W'(SIG_OFS));
    assign rsh = SH_W'(-sh);
    assign keep_mask = ~({(MAN_W+1){1'b1}} << rsh[4:0]);

    always_comb begin
        sc.sign = fields.sign;
        sc.nan  = 1'b0;
        sc.big  = 1'b0;
        sc.lost = 1'b0;
        sc.mag  = '0;
        unique case (fields.cls)
            CLS_NAN:  sc.nan = 1'b1;
            CLS_INF:  sc.big = 1'b1;
            CLS_SUB:  sc.lost = |fields.sig;
            CLS_NORM: begin
                if (sh >= $signed(SH_W'(BIG_SH))) begin
                    sc.big = 1'b1;
                end else if (sh >= 0) begin
                    sc.mag = WORD_W'(fields.sig) << sh[4:0];
                end else if (rsh > SH_W'(MAN_W)) begin
                    sc.lost = 1'b1;
                end else begin
                    sc.mag  = WORD_W'(fields.sig >> rsh[4:0]);
                    sc.lost = |(fields.sig & keep_mask);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/f2x_saturate.sv
module f2x_saturate
    import f2x_pkg::*;
(
    input  scaled_t   sc,
    input  logic      is_signed,
    input  logic      is_half,
    output conv_res_t res
);
    localparam logic [WORD_W:0] U_WORD_MAX = {1'b0, {WORD_W{1'b1}}};
    localparam logic [WORD_W:0] U_HALF_MAX = (WORD_W+1)'({HALF_W{1'b1}});
    localparam logic [WORD_W:0] S_WORD_POS = (WORD_W+1)'({(WORD_W-1){1'b1}});
    localparam logic [WORD_W:0] S_WORD_NEG = (WORD_W+1)'(1) << (WORD_W-1);
    localparam logic [WORD_W:0] S_HALF_POS = (WORD_W+1)'({(HALF_W-1){1'b1}});
    localparam logic [WORD_W:0] S_HALF_NEG = (WORD_W+1)'(1) << (HALF_W-1);

    logic [WORD_W:0]   pos_lim;
    logic [WORD_W:0]   neg_lim;
    logic [WORD_W-1:0] hi_pat;
    logic [WORD_W-1:0] lo_pat;
    logic              ovf;

    always_comb begin
        if (is_signed) begin
            pos_lim = is_half ? S_HALF_POS : S_WORD_POS;
            neg_lim = is_half ? S_HALF_NEG : S_WORD_NEG;
            lo_pat  = WORD_W'(-neg_lim);
        end else begin
            pos_lim = is_half ? U_HALF_MAX : U_WORD_MAX;
            neg_lim = '0;
            lo_pat  = '0;
        end
        hi_pat = pos_lim[WORD_W-1:0];
        ovf    = sc.big || ({1'b0, sc.mag} > (sc.sign ? neg_lim : pos_lim));

        if (sc.nan) begin
            res.value   = '0;
            res.invalid = 1'b1;
        end else if (ovf) begin
            res.value   = sc.sign ? lo_pat : hi_pat;
            res.invalid = 1'b1;
        end else begin
            res.value   = sc.sign ? (~sc.mag + 1'b1) : sc.mag;
            res.invalid = 1'b0;
        end
        res.inexact = sc.lost && !res.invalid;
    end
endmodule

// File: rtl/f2x_conv.sv
module f2x_conv
    import f2x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   operand,
    input  logic              is_signed,
    input  logic              is_half,
    input  logic              imm_lo,
    input  logic [IMM_W-2:0]  imm_hi,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              invalid,
    output logic              inexact
);
    fp_fields_t        fields;
    scaled_t           sc;
    conv_res_t         res;
    logic [FRAC_W-1:0] frac;

    assign frac = frac_count(is_half, {imm_hi, imm_lo});

    f2x_unpack u_unpack (
        .operand (operand),
        .fields  (fields)
    );

    f2x_scale u_scale (
        .fields (fields),
        .frac   (frac),
        .sc     (sc)
    );

    f2x_saturate u_sat (
        .sc        (sc),
        .is_signed (is_signed),
        .is_half   (is_half),
        .res       (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
            inexact   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= res.value;
                invalid <= res.invalid;
                inexact <= res.inexact;
            end
        end
    end
endmodule

// File: rtl/f2x_conv_chk.sv
module f2x_conv_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] operand,
    input logic        is_signed,
    input logic        is_half,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        invalid,
    input logic        inexact
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !invalid && !inexact && result == 32'h0));
    // R3
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(invalid && inexact));
    // R5
    half_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_half && is_signed) |=> (result[31:16] == {16{result[15]}}));
    // R6
    half_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_half && !is_signed) |=> (result[31:16] == 16'h0));
    // R7
    nan_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && operand[30:23] == 8'hFF && operand[22:0] != 23'h0)
        |=> (invalid && !inexact && result == 32'h0));
    // R9
    zero_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && operand[30:0] == 31'h0) |=> (!invalid && !inexact && result == 32'h0));
endmodule

bind f2x_conv f2x_conv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .is_signed (is_signed),
    .is_half   (is_half),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid),
    .inexact   (inexact)
);

// File: tb/f2x_conv_tb.sv
module f2x_conv_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic        is_signed = 1'b0;
    logic        is_half = 1'b0;
    logic        imm_lo = 1'b0;
    logic [3:0]  imm_hi = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        invalid;
    logic        inexact;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit prev_inv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f2x_conv u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .operand (operand),
        .is_signed (is_signed), .is_half (is_half), .imm_lo (imm_lo), .imm_hi (imm_hi),
        .out_valid (out_valid), .result (result), .invalid (invalid), .inexact (inexact)
    );

    // behavioural reference: real arithmetic, truncate, then range check
    task automatic ref_model(input logic [31:0] op, input logic sgn, input logic hlf,
                             input logic [4:0] imm, output logic [31:0] v,
                             output logic inv, output logic inx);
        int    width;
        int    frac;
        int    e;
        longint m;
        real   r;
        bit    big;
        bit    lost;
        longint mag;
        longint sv;
        longint hi;
        longint lo;
        longint val;
        width = hlf ? 16 : 32;
        frac  = (int'(imm) > width) ? 0 : width - int'(imm);
        e = int'(op[30:23]);
        m = longint'(op[22:0]);
        big = 0; lost = 0; mag = 0;
        if (sgn) begin
            hi = (longint'(1) << (width - 1)) - 1;
            lo = -(longint'(1) << (width - 1));
        end else begin
            hi = (longint'(1) << width) - 1;
            lo = 0;
        end
        if (e == 255 && m != 0) begin
            v = 32'h0; inv = 1'b1; inx = 1'b0;
            return;
        end
        if (e == 255) begin
            big = 1;
        end else begin
            if (e == 0) r = real'(m) * (2.0 ** real'(-149));
            else        r = (8388608.0 + real'(m)) * (2.0 ** real'(e - 150));
            r = r * (2.0 ** real'(frac));
            if (r >= 4294967296.0) big = 1;
            else begin
                mag  = longint'($floor(r));
                lost = (r != $floor(r));
            end
        end
        sv = op[31] ? -mag : mag;
        inv = 1'b0;
        if (big) begin
            inv = 1'b1; val = op[31] ? lo : hi;
        end else if (sv > hi) begin
            inv = 1'b1; val = hi;
        end else if (sv < lo) begin
            inv = 1'b1; val = lo;
        end else begin
            val = sv;
        end
        v   = val[31:0];
        inx = lost && !inv;
    endtask

    function automatic string pick_tag(input logic [31:0] op, input logic sgn,
                                       input logic hlf, input logic inv,
                                       input logic inx, input bit pinv);
        if (op[30:23] == 8'hFF && op[22:0] != 0) return "R7";
        if (op[30:23] == 8'hFF) return "R8";
        if (op[30:23] == 8'h00) return "R9";
        if (pinv && !inv) return "R10";
        if (inv && sgn && !hlf) return "R4";
        if (sgn && hlf) return "R5";
        if (!sgn && (inv || hlf || op[31])) return "R6";
        if (inx) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // compare every cycle just after the active edge
    always @(posedge clk) begin
        logic [31:0] ev;
        logic        ei;
        logic        ex;
        string       tg;
        #2;
        if (!done) begin
            if (rst) begin
                check("R1", "reset out_valid", {31'h0, out_valid}, 32'h0);
                check("R1", "reset result", result, 32'h0);
                check("R1", "reset flags", {30'h0, invalid, inexact}, 32'h0);
            end else begin
                check("R1", "out_valid", {31'h0, out_valid}, {31'h0, in_valid});
                if (in_valid) begin
                    ref_model(operand, is_signed, is_half, {imm_hi, imm_lo}, ev, ei, ex);
                    tg = pick_tag(operand, is_signed, is_half, ei, ex, prev_inv);
                    check(tg, "result", result, ev);
                    check(tg, "invalid", {31'h0, invalid}, {31'h0, ei});
                    check(tg, "inexact", {31'h0, inexact}, {31'h0, ex});
                    prev_inv = ei;
                end
            end
        end
    end

    task automatic drive(input logic [31:0] op, input logic sgn, input logic hlf,
                         input logic [4:0] imm);
        operand   = op;
        is_signed = sgn;
        is_half   = hlf;
        imm_lo    = imm[0];
        imm_hi    = imm[4:1];
        in_valid  = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 scaling: 1.0 with F=1 -> 2; -2.75 with F=2 -> -11
        drive(32'h3F800000, 1, 0, 5'd31);
        drive(32'hC0300000, 1, 0, 5'd30);
        // R2 clamp of fraction count: halfword imm 20 -> F=0
        drive(32'h40A00000, 0, 1, 5'd20);
        // R3 truncation: 1.5 F=0 -> 1 inexact; -2.5 signed -> -2
        drive(32'h3FC00000, 0, 1, 5'd16);
        drive(32'hC0200000, 1, 1, 5'd16);
        // R4 signed word limits
        drive(32'h501502F9, 1, 0, 5'd31);
        drive(32'hD01502F9, 1, 0, 5'd31);
        drive(32'hCE800000, 1, 0, 5'd31);
        drive(32'h4E800000, 1, 0, 5'd31);
        // R10 exact after invalid
        drive(32'h3F800000, 1, 0, 5'd31);
        // R5 signed halfword limits
        drive(32'h471C4000, 1, 1, 5'd16);
        drive(32'hC7000000, 1, 1, 5'd16);
        drive(32'hC7000100, 1, 1, 5'd16);
        drive(32'h46FFFE00, 1, 1, 5'd16);
        // R6 unsigned
        drive(32'h477FFF00, 0, 1, 5'd16);
        drive(32'h47800000, 0, 1, 5'd16);
        drive(32'hBF000000, 0, 1, 5'd16);
        drive(32'hBF800000, 0, 1, 5'd16);
        drive(32'h4F800000, 0, 0, 5'd31);
        drive(32'h4EFFFFFF, 0, 0, 5'd31);
        // R7 NaN, R8 infinities
        drive(32'h7FC00000, 1, 0, 5'd31);
        drive(32'hFF800001, 0, 1, 5'd16);
        drive(32'h7F800000, 1, 1, 5'd16);
        drive(32'hFF800000, 1, 0, 5'd31);
        drive(32'hFF800000, 0, 0, 5'd31);
        drive(32'h7F800000, 0, 0, 5'd31);
        // R9 zeros and denormals
        drive(32'h00000000, 1, 0, 5'd0);
        drive(32'h80000000, 0, 1, 5'd16);
        drive(32'h00000001, 1, 0, 5'd0);
        drive(32'h807FFFFF, 0, 1, 5'd0);
        // gap cycle
        in_valid = 1'b0;
        @(negedge clk);
        // broad sweep
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] op;
            logic [31:0] rr;
            rr = $urandom;
            if (k % 5 == 0) op = $urandom;
            else op = {rr[31], 8'(100 + (rr[7:0] % 60)), 23'($urandom)};
            in_valid = (k % 7 != 3);
            operand = op; is_signed = rr[9]; is_half = rr[10];
            imm_lo = rr[11]; imm_hi = rr[15:12];
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=expired exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule